// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Status Flags

This block receives asynchronous serial characters on a single line and presents them to a host through two read-only registers: a status byte and a one-deep data buffer. The line is sampled on an oversampling tick that runs at 16 times the bit rate and comes from outside the block. Each character has one start bit, eight data bits sent LSB first, an optional parity bit (even or odd) and one stop bit. Every bit is settled by a majority vote of three samples taken around the middle of the bit.

The host reads through a one-cycle read strobe and a one-bit register select. The data is presented combinationally, so the value on `rd_data` in the strobe cycle is the value being read. The strobe cycle itself carries the side effects. The error flags and the character-ready flag are sticky. They are released only by a two-step sequence: a status read, then a data read. The release applies only to the flags that were already set when the status register was read.

Top module: `uart_rx_status`

## Requirements
- R1: A start bit is accepted when the line is low on an oversample tick after it was high on the previous tick. If the vote taken mid-way through the start bit is high, the receiver returns to idle and no flag or data changes.
- R2: Status bit 4 (idle) reads 0 from the cycle after a start bit is detected until the stop bit has been decided, and reads 1 at all other times.
- R3: Counting the detection tick as tick 0, each bit is sampled on ticks 7, 8 and 9 of its 16-tick slot and decided by a 2-of-3 vote. Data bits arrive LSB first, and the vote result is the stored bit.
- R4: With `par_en`=1, a parity bit follows the data bits. For even mode (`par_odd`=0) it equals the XOR of the data bits; for odd mode it equals the inverse of that XOR. A mismatch sets status bit 0. With `par_en`=0 no parity bit is expected and bit 0 never sets.
- R5: A low stop-bit vote sets status bit 2 (framing error) for that character.
- R6: If the three samples of any bit of a character disagree, status bit 1 (noise) sets in the same cycle that the character sets status bit 5. It does not set for a character that is dropped by an overrun.
- R7: The buffer holds one character. A character that completes while the buffer is full, or while status bit 3 (overrun) is set, is dropped. It sets bit 3 and leaves the data register and status bits 0, 1, 2 and 5 unchanged.
- R8: Loading a character sets status bit 5. It clears only when a data read follows a status read that saw it set, and no new character loads in that same cycle.
- R9: Status bits 0 to 3 clear on a data read only when each was 1 at the most recent status read. A data read ends that arming. A data read with no status read before it clears nothing. A flag raised after the status read survives.
- R10: `rd_sel`=0 selects the status byte {0, 0, ready, idle, overrun, framing, noise, parity}, with bits 7:6 always 0. `rd_sel`=1 selects the data register.
- R11: After reset the status byte is 0x10 and the data register reads 0x00.
- R12: A data read in the same cycle that a character completes returns the old character. The new character then loads without overrun, and status bit 5 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| par_en | input | 1 | Expect a parity bit after the data bits |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_en | input | 1 | Read strobe; side effects occur in this cycle |
| rd_sel | input | 1 | 0 selects the status register, 1 selects the data register |
| rd_data | output | 8 | Selected register contents, combinational |

## Verification
The case that matters is a host data read landing in the very clock where a new character's stop bit is decided. The pop of the old character and the load of the new one then meet in the buffer, and the ready-flag clear meets the ready-flag set. The bench arms the sequence with a status read and holds the read strobe exactly on the oversample tick that decides the stop bit. It then judges that the strobe returned the old byte, that no overrun was raised, and that the ready flag and the new byte are both present afterwards.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned RX_DW = 8;

  // status byte bit positions (host software decodes these)
  localparam int unsigned SB_PAR   = 0;
  localparam int unsigned SB_NOISE = 1;
  localparam int unsigned SB_FRAME = 2;
  localparam int unsigned SB_OVR   = 3;
  localparam int unsigned SB_IDLE  = 4;
  localparam int unsigned SB_RDY   = 5;

  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_START = 3'd1,
    FR_DATA  = 3'd2,
    FR_PAR   = 3'd3,
    FR_STOP  = 3'd4
  } frame_state_e;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             frame_err;
    logic             par_err;
    logic             noisy;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RESET_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_bitvote.sv
module uart_rx_bitvote #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic start_i,
  input  logic active_i,
  input  logic rx_i,
  output logic bit_valid_o,
  output logic bit_val_o,
  output logic bit_noise_o
);
  localparam int unsigned CW    = $clog2(OSR);
  localparam int unsigned MID   = OSR / 2;
  localparam logic [CW-1:0] T_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] T_MID = CW'(MID);
  localparam logic [CW-1:0] T_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] T_END = CW'(OSR - 1);

  logic [CW-1:0] ctr_q, ctr_d;
  logic          s_lo_q, s_lo_d, s_mid_q, s_mid_d;
  logic          adv;

  assign adv = os_tick && active_i;

  always_comb begin
    ctr_d   = ctr_q;
    s_lo_d  = s_lo_q;
    s_mid_d = s_mid_q;
    if (start_i) begin
      ctr_d = CW'(1);
    end else if (adv) begin
      ctr_d = (ctr_q == T_END) ? '0 : ctr_q + CW'(1);
      if (ctr_q == T_LO)  s_lo_d  = rx_i;
      if (ctr_q == T_MID) s_mid_d = rx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q   <= '0;
      s_lo_q  <= 1'b1;
      s_mid_q <= 1'b1;
    end else begin
      ctr_q   <= ctr_d;
      s_lo_q  <= s_lo_d;
      s_mid_q <= s_mid_d;
    end
  end

  assign bit_valid_o = adv && (ctr_q == T_HI);
  assign bit_val_o   = (s_lo_q & s_mid_q) | (s_lo_q & rx_i) | (s_mid_q & rx_i);
  assign bit_noise_o = !((s_lo_q == s_mid_q) && (s_mid_q == rx_i));

  // R3: a decision is only taken while a frame is running
  a_r3_vote_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> (active_i && os_tick && !start_i));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     os_tick,
  input  logic     rx_i,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     bit_valid_i,
  input  logic     bit_val_i,
  input  logic     bit_noise_i,
  output logic     start_o,
  output logic     busy_o,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int unsigned BCW = $clog2(RX_DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(RX_DW - 1);

  frame_state_e     st_q, st_d;
  logic [RX_DW-1:0] sh_q, sh_d;
  logic [BCW-1:0]   bc_q, bc_d;
  logic             noise_q, noise_d, perr_q, perr_d, hi_q, hi_d;

  assign start_o = (st_q == FR_IDLE) && os_tick && !rx_i && hi_q;
  assign busy_o  = (st_q != FR_IDLE);

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    bc_d    = bc_q;
    noise_d = noise_q;
    perr_d  = perr_q;
    hi_d    = os_tick ? rx_i : hi_q;
    done_o  = 1'b0;
    unique case (st_q)
      FR_IDLE: if (start_o) begin
        st_d    = FR_START;
        noise_d = 1'b0;
        perr_d  = 1'b0;
      end
      FR_START: if (bit_valid_i) begin
        if (bit_val_i) st_d = FR_IDLE;
        else begin
          st_d    = FR_DATA;
          bc_d    = '0;
          noise_d = bit_noise_i;
        end
      end
      FR_DATA: if (bit_valid_i) begin
        sh_d    = {bit_val_i, sh_q[RX_DW-1:1]};
        noise_d = noise_q | bit_noise_i;
        if (bc_q == LAST_BIT) st_d = par_en ? FR_PAR : FR_STOP;
        else                  bc_d = bc_q + BCW'(1);
      end
      FR_PAR: if (bit_valid_i) begin
        noise_d = noise_q | bit_noise_i;
        perr_d  = bit_val_i != ((^sh_q) ^ par_odd);
        st_d    = FR_STOP;
      end
      FR_STOP: if (bit_valid_i) begin
        st_d   = FR_IDLE;
        done_o = 1'b1;
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FR_IDLE;
      sh_q    <= '0;
      bc_q    <= '0;
      noise_q <= 1'b0;
      perr_q  <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      bc_q    <= bc_d;
      noise_q <= noise_d;
      perr_q  <= perr_d;
      hi_q    <= hi_d;
    end
  end

  assign char_o.data      = sh_q;
  assign char_o.frame_err = !bit_val_i;
  assign char_o.par_err   = perr_q;
  assign char_o.noisy     = noise_q | bit_noise_i;

  // R2: detection makes the receiver busy on the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);
  // R2: the stop decision returns the receiver to idle
  a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R4: no parity error can be reported with parity disabled
  a_r4_no_perr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !par_en && $past(!par_en)) |-> !char_o.par_err);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_i,
  input  rx_char_t   char_i,
  input  logic       busy_i,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data
);
  logic [RX_DW-1:0] buf_q, buf_d;
  logic full_q, full_d, rdy_q, rdy_d, ovr_q, ovr_d;
  logic frm_q, frm_d, nse_q, nse_d, par_q, par_d;
  logic [4:0] arm_q, arm_d;   // {rdy, ovr, frm, nse, par} seen at last status read
  logic [7:0] stat;
  logic stat_rd, data_rd, load, drop;

  assign stat    = {2'b00, rdy_q, !busy_i, ovr_q, frm_q, nse_q, par_q};
  assign stat_rd = rd_en && !rd_sel;
  assign data_rd = rd_en && rd_sel;
  assign load    = done_i && !ovr_q && (!full_q || data_rd);
  assign drop    = done_i && !load;

  always_comb begin
    buf_d  = load ? char_i.data : buf_q;
    full_d = load || (full_q && !data_rd);
    rdy_d  = load || (rdy_q && !(data_rd && arm_q[4]));
    ovr_d  = drop || (ovr_q && !(data_rd && arm_q[3]));
    frm_d  = (load && char_i.frame_err) || (frm_q && !(data_rd && arm_q[2]));
    nse_d  = (load && char_i.noisy)     || (nse_q && !(data_rd && arm_q[1]));
    par_d  = (load && char_i.par_err)   || (par_q && !(data_rd && arm_q[0]));
    if (stat_rd)      arm_d = {stat[SB_RDY], stat[SB_OVR:SB_PAR]};
    else if (data_rd) arm_d = '0;
    else              arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0; full_q <= 1'b0; rdy_q <= 1'b0; ovr_q <= 1'b0;
      frm_q <= 1'b0; nse_q <= 1'b0; par_q <= 1'b0; arm_q <= '0;
    end else begin
      buf_q <= buf_d; full_q <= full_d; rdy_q <= rdy_d; ovr_q <= ovr_d;
      frm_q <= frm_d; nse_q <= nse_d; par_q <= par_d; arm_q <= arm_d;
    end
  end

  assign rd_data = rd_sel ? buf_q : stat;

  // R7: while overrun is pending a completing character leaves the data register alone
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && ovr_q) |=> $stable(buf_q));
  // R6: the noise flag only rises together with a completing character that loads
  a_r6_noise_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nse_q) |-> (rdy_q && $past(done_i) && !$past(ovr_q)));
  // R8: the ready flag never drops without a data read
  a_r8_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !data_rd) |=> rdy_q);
  // R9: an unarmed data read leaves the framing flag set
  a_r9_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q && data_rd && !arm_q[2]) |=> frm_q);
  // R12: pop and load in one cycle gives no overrun and keeps ready
  a_r12_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && data_rd && !ovr_q) |=> (rdy_q && !ovr_q));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR       = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data
);
  logic     rst_core_n, rx_s, start, busy, done;
  logic     bv_valid, bv_val, bv_noise;
  rx_char_t chr;

  uart_rx_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_core_n));

  uart_rx_sync #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(rx_in), .q_o(rx_s));

  uart_rx_bitvote #(.OSR(OSR)) u_vote (
    .clk(clk), .rst_n(rst_core_n), .os_tick(os_tick), .start_i(start),
    .active_i(busy), .rx_i(rx_s), .bit_valid_o(bv_valid),
    .bit_val_o(bv_val), .bit_noise_o(bv_noise));

  uart_rx_frame u_frame (
    .clk(clk), .rst_n(rst_core_n), .os_tick(os_tick), .rx_i(rx_s),
    .par_en(par_en), .par_odd(par_odd), .bit_valid_i(bv_valid),
    .bit_val_i(bv_val), .bit_noise_i(bv_noise), .start_o(start),
    .busy_o(busy), .done_o(done), .char_o(chr));

  uart_rx_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .done_i(done), .char_i(chr),
    .busy_i(busy), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data));
endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/100ps
module uart_rx_status_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst_n, rx_in, par_en, par_odd, rd_en, rd_sel, os_tick;
  logic [7:0] rd_data;
  logic [1:0] tcnt = 2'd0;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign os_tick = (tcnt == 2'd3);

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data));

  typedef struct {
    logic [7:0] st_pre;
    logic [7:0] data;
    logic [7:0] st_post;
    string      req;
  } exp_t;
  exp_t sbq[$];

  int checks = 0;
  int errors = 0;
  logic [7:0] coll_data;
  logic [7:0] v;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit rd);
    @(negedge clk);
    while (!os_tick) @(negedge clk);
    if (rd) begin
      rd_sel = 1'b1; #0.5; coll_data = rd_data; rd_en = 1'b1;
    end
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd_reg(input bit sel, output logic [7:0] val);
    @(negedge clk);
    rd_sel = sel; #0.5;
    val = rd_data;
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // driver: serialises one character; noise_bit 0 = start, i+1 = data bit i
  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit stop_val,
                           input int noise_bit, input bit collide);
    logic b [0:10];
    int n = 0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < 8; i++) begin b[n] = d[i]; n++; end
    if (par_en) begin b[n] = (^d) ^ par_odd ^ bad_par; n++; end
    b[n] = stop_val; n++;
    wait_tick(1'b0);
    for (int k = 0; k < n; k++) begin
      rx_in = b[k];
      for (int t = 1; t <= 16; t++) begin
        wait_tick(collide && (k == n - 1) && (t == 10));
        if (k == noise_bit && t == 8) rx_in = ~b[k];
        if (k == noise_bit && t == 9) rx_in = b[k];
      end
    end
    rx_in = 1'b1;
    repeat (3) wait_tick(1'b0);
  endtask

  task automatic push(input logic [7:0] pre, input logic [7:0] d,
                      input logic [7:0] post, input string req);
    exp_t e;
    e.st_pre = pre; e.data = d; e.st_post = post; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: status read, data read, status read, compared against the queue head
  task automatic pop_check();
    exp_t e;
    logic [7:0] r;
    e = sbq.pop_front();
    rd_reg(1'b0, r); chk({e.req, " status"}, r, e.st_pre);
    rd_reg(1'b1, r); chk({e.req, " data"}, r, e.data);
    rd_reg(1'b0, r); chk({e.req, " cleared"}, r, e.st_post);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    rd_en = 1'b0; rd_sel = 1'b0;
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (20) @(posedge clk);

    // R11 / R10: reset values
    rd_reg(1'b0, v); chk("R11 reset status", v, 8'h10);
    rd_reg(1'b1, v); chk("R11 reset data", v, 8'h00);

    // R3 / R8: plain character, parity off
    send_char(8'h55, 1'b0, 1'b1, -1, 1'b0);
    push(8'h30, 8'h55, 8'h10, "R8 R3 plain");
    pop_check();

    // R2: idle bit low mid-frame
    fork
      send_char(8'hA3, 1'b0, 1'b1, -1, 1'b0);
      begin repeat (80) @(posedge clk); rd_reg(1'b0, v); chk("R2 busy", v, 8'h00); end
    join
    push(8'h30, 8'hA3, 8'h10, "R2 R3 after frame");
    pop_check();

    // R1: false start, low for four ticks only
    wait_tick(1'b0);
    rx_in = 1'b0;
    repeat (4) wait_tick(1'b0);
    rx_in = 1'b1;
    repeat (30) wait_tick(1'b0);
    rd_reg(1'b0, v); chk("R1 false start", v, 8'h10);

    // R4: parity modes
    par_en = 1'b1; par_odd = 1'b0;
    send_char(8'h3C, 1'b0, 1'b1, -1, 1'b0);
    push(8'h30, 8'h3C, 8'h10, "R4 even ok"); pop_check();
    send_char(8'h3C, 1'b1, 1'b1, -1, 1'b0);
    push(8'h31, 8'h3C, 8'h10, "R4 even bad"); pop_check();
    par_odd = 1'b1;
    send_char(8'h3D, 1'b0, 1'b1, -1, 1'b0);
    push(8'h30, 8'h3D, 8'h10, "R4 odd ok"); pop_check();
    send_char(8'h3D, 1'b1, 1'b1, -1, 1'b0);
    push(8'h31, 8'h3D, 8'h10, "R4 odd bad"); pop_check();
    par_en = 1'b0; par_odd = 1'b0;

    // R5 / R9: framing error, unarmed data read clears nothing
    send_char(8'h81, 1'b0, 1'b0, -1, 1'b0);
    rd_reg(1'b1, v); chk("R9 unarmed data", v, 8'h81);
    push(8'h34, 8'h81, 8'h10, "R5 R9 framing"); pop_check();

    // R6 / R3: glitch on data bit 3, vote still correct
    send_char(8'h96, 1'b0, 1'b1, 4, 1'b0);
    push(8'h32, 8'h96, 8'h10, "R6 R3 noise"); pop_check();

    // R9: flag raised after the status read survives the data read
    rd_reg(1'b0, v); chk("R9 armed empty", v, 8'h10);
    send_char(8'h7E, 1'b0, 1'b0, -1, 1'b0);
    rd_reg(1'b1, v); chk("R9 late flag data", v, 8'h7E);
    push(8'h34, 8'h7E, 8'h10, "R9 late flag"); pop_check();

    // R7 / R6: overrun, noisy second char gives no noise flag
    send_char(8'h11, 1'b0, 1'b1, -1, 1'b0);
    send_char(8'h22, 1'b0, 1'b1, 2, 1'b0);
    push(8'h38, 8'h11, 8'h10, "R7 R6 overrun"); pop_check();

    // R7: overrun blocks transfer even with the buffer drained
    send_char(8'h44, 1'b0, 1'b1, -1, 1'b0);
    send_char(8'h55, 1'b0, 1'b1, -1, 1'b0);
    rd_reg(1'b1, v); chk("R7 drain", v, 8'h44);
    send_char(8'h66, 1'b0, 1'b0, -1, 1'b0);
    push(8'h38, 8'h44, 8'h10, "R7 blocked"); pop_check();

    // R12: data read in the completion cycle
    send_char(8'h5A, 1'b0, 1'b1, -1, 1'b0);
    rd_reg(1'b0, v); chk("R12 armed", v, 8'h30);
    send_char(8'hC3, 1'b0, 1'b1, -1, 1'b1);
    chk("R12 old byte", coll_data, 8'h5A);
    push(8'h30, 8'hC3, 8'h10, "R12 new byte"); pop_check();

    finish_run();
  end
endmodule